// File: doc/BRIEF.md
# Priority-Level Maskable Interrupt Controller

The block gathers a bank of maskable interrupt request lines and offers the CPU one winning request at a time. Each source has a small control register with three fields: a mask bit, a pending flag and a programmable priority level. A rising edge on a request line latches the pending flag. The flag stays set while the source is masked and while the CPU has interrupts disabled. It is cleared only when the CPU acknowledges the source or when software writes the flag to zero.

Among the eligible pending sources, the one with the numerically lowest level wins. When several sources share that level, the lowest source index wins. The CPU tells the block whether a maskable service is already running and at which level. While a service is running, only a strictly more urgent level is offered, so a request at the same level waits until the service ends. The winner is registered. A request line that is sampled high at a clock edge is presented at that same edge.

Top module: `prio_intc`

## Requirements
- R1: After reset, every source reads back as mask 1, pending 0 and level all ones (control byte 8'h87 with the default 3-bit level), and `irq_valid_o` is 0.
- R2: When a request line is 1 at an edge and was 0 at the previous edge, the pending flag of that source is set. Pending reads back as bit 6 of the control byte. A line held high does not set the flag again after it has been cleared.
- R3: A masked source (bit 7 = 1) keeps its pending flag and is never presented. Clearing the mask while the flag is set makes the source eligible at the edge of that write.
- R4: While `cpu_id_i` or `cpu_np_i` is 1, no source is presented and pending flags are kept. Once both inputs are 0, the highest-priority pending source is presented at the next edge.
- R5: Level 0 is the most urgent level. Among the eligible sources, the one with the numerically lowest level is presented, and `irq_level_o` carries that level.
- R6: When several eligible sources share the lowest level, the source with the lowest index is presented.
- R7: While `svc_active_i` is 1, only sources whose level is strictly lower than `svc_level_i` are eligible. A source at an equal or higher level stays pending.
- R8: Driving `ack_i` high while `irq_valid_o` is 1 clears the pending flag of the presented source. At the same edge, the outputs switch to the next winner, or to no request.
- R9: A write to index `wr_idx_i` loads the mask from bit 7 and the level from bits 2:0. It clears pending when bit 6 is 0 and leaves pending unchanged when bit 6 is 1. A write to an index of NUM_SRC or above changes no source.
- R10: For an eligible source, `irq_valid_o` rises at the first edge that samples its request line high, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Raw request lines, edge-detected |
| wr_en_i | input | 1 | Control register write strobe |
| wr_idx_i | input | IDX_W | Source index for the write |
| wr_data_i | input | 8 | Write byte: [7] mask, [6] keep-pending, [LVL_W-1:0] level |
| rd_idx_i | input | IDX_W | Source index for the readback |
| rd_data_o | output | 8 | Control byte of the selected source: [7] mask, [6] pending, [LVL_W-1:0] level |
| cpu_id_i | input | 1 | CPU interrupt-disable status |
| cpu_np_i | input | 1 | CPU non-maskable-in-service status |
| svc_active_i | input | 1 | A maskable service is in progress |
| svc_level_i | input | LVL_W | Level of the service in progress |
| ack_i | input | 1 | Acknowledge of the presented source |
| irq_valid_o | output | 1 | A winning request is presented |
| irq_idx_o | output | IDX_W | Index of the winning source |
| irq_level_o | output | LVL_W | Level of the winning source |

## Verification
The bench builds the block with its defaults: 33 sources, 3-bit levels and the tree arbiter. With these values the top index 32 sits alone in the upper half of the 64-leaf tree, next to padding leaves. A 6-bit index also lets the bench write out-of-range indices such as 40. Directed sequences cover ties, strict nesting, masked holding and the CPU status gating. A random phase mixes edges, writes and acknowledges, and a behavioural model is compared against the outputs on every clock.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
   localparam int CTRL_W    = 8;
   localparam int MASK_POS  = 7;
   localparam int PEND_POS  = 6;
   localparam int MAX_LVL_W = 6;

   typedef enum logic [0:0] {
      ARB_TREE   = 1'b0,
      ARB_LINEAR = 1'b1
   } arb_style_e;

   function automatic logic [CTRL_W-1:0] ctrl_pack(
      input logic                 mask,
      input logic                 pend,
      input logic [MAX_LVL_W-1:0] lvl
   );
      logic [CTRL_W-1:0] b;
      b = '0;
      b[MASK_POS] = mask;
      b[PEND_POS] = pend;
      b[MAX_LVL_W-1:0] = lvl;
      return b;
   endfunction
endpackage

// File: rtl/prio_intc_src.sv
module prio_intc_src
   import prio_intc_pkg::*;
#(
   parameter int LVL_W  = 3,
   parameter int IDX_W  = 6,
   parameter int SRC_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   input  logic              ack_hit_i,
   output logic              mask_nx_o,
   output logic              pend_nx_o,
   output logic [LVL_W-1:0]  lvl_nx_o,
   output logic              mask_q_o,
   output logic              pend_q_o,
   output logic [LVL_W-1:0]  lvl_q_o,
   output logic              req_q_o
);
   localparam logic [IDX_W-1:0] MY_ID = IDX_W'(SRC_ID);

   logic wr_hit;
   logic edge_seen;

   assign wr_hit    = wr_en_i && (wr_idx_i == MY_ID);
   assign edge_seen = req_i && !req_q_o;

   always_comb begin
      mask_nx_o = mask_q_o;
      lvl_nx_o  = lvl_q_o;
      pend_nx_o = pend_q_o;
      if (wr_hit) begin
         mask_nx_o = wr_data_i[MASK_POS];
         lvl_nx_o  = wr_data_i[LVL_W-1:0];
         if (!wr_data_i[PEND_POS]) pend_nx_o = 1'b0;
      end
      if (ack_hit_i) pend_nx_o = 1'b0;
      if (edge_seen) pend_nx_o = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q_o <= 1'b1;
         pend_q_o <= 1'b0;
         lvl_q_o  <= '1;
         req_q_o  <= 1'b0;
      end else begin
         mask_q_o <= mask_nx_o;
         pend_q_o <= pend_nx_o;
         lvl_q_o  <= lvl_nx_o;
         req_q_o  <= req_i;
      end
   end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
   import prio_intc_pkg::*;
#(
   parameter int         NUM_SRC = 33,
   parameter int         LVL_W   = 3,
   parameter int         IDX_W   = 6,
   parameter arb_style_e STYLE   = ARB_TREE
) (
   input  logic [NUM_SRC-1:0]            elig_i,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
   output logic                          win_v_o,
   output logic [IDX_W-1:0]              win_idx_o,
   output logic [LVL_W-1:0]              win_lvl_o
);
   localparam int LEAVES = 1 << IDX_W;

   if (STYLE == ARB_TREE) begin : g_tree
      logic             nv [1:2*LEAVES-1];
      logic [IDX_W-1:0] ni [1:2*LEAVES-1];
      logic [LVL_W-1:0] nl [1:2*LEAVES-1];

      for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
         if (g < NUM_SRC) begin : g_real
            assign nv[LEAVES+g] = elig_i[g];
            assign nl[LEAVES+g] = lvl_i[g];
            assign ni[LEAVES+g] = IDX_W'(g);
         end else begin : g_pad
            assign nv[LEAVES+g] = 1'b0;
            assign nl[LEAVES+g] = '1;
            assign ni[LEAVES+g] = '0;
         end
      end

      for (genvar g = 1; g < LEAVES; g++) begin : g_node
         logic take_left;
         assign take_left = nv[2*g] && (!nv[2*g+1] || (nl[2*g] <= nl[2*g+1]));
         assign nv[g] = nv[2*g] || nv[2*g+1];
         assign nl[g] = take_left ? nl[2*g] : nl[2*g+1];
         assign ni[g] = take_left ? ni[2*g] : ni[2*g+1];
      end

      assign win_v_o   = nv[1];
      assign win_idx_o = ni[1];
      assign win_lvl_o = nl[1];
   end else begin : g_linear
      always_comb begin
         win_v_o   = 1'b0;
         win_idx_o = '0;
         win_lvl_o = '1;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_i[i] && (!win_v_o || (lvl_i[i] < win_lvl_o))) begin
               win_v_o   = 1'b1;
               win_idx_o = IDX_W'(i);
               win_lvl_o = lvl_i[i];
            end
         end
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int         NUM_SRC = 33,
   parameter int         LVL_W   = 3,
   parameter arb_style_e STYLE   = ARB_TREE,
   localparam int        IDX_W   = $clog2(NUM_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  req_i,
   input  logic                wr_en_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [CTRL_W-1:0]   wr_data_i,
   input  logic [IDX_W-1:0]    rd_idx_i,
   output logic [CTRL_W-1:0]   rd_data_o,
   input  logic                cpu_id_i,
   input  logic                cpu_np_i,
   input  logic                svc_active_i,
   input  logic [LVL_W-1:0]    svc_level_i,
   input  logic                ack_i,
   output logic                irq_valid_o,
   output logic [IDX_W-1:0]    irq_idx_o,
   output logic [LVL_W-1:0]    irq_level_o
);
   if (NUM_SRC < 2) begin : g_bad_num
      $error("prio_intc: NUM_SRC must be at least 2");
   end
   if (LVL_W < 1 || LVL_W > MAX_LVL_W) begin : g_bad_lvl
      $error("prio_intc: LVL_W must lie in 1..6 to fit the control byte");
   end

   logic [NUM_SRC-1:0]            mask_nx, pend_nx, mask_vec, pend_vec, req_q;
   logic [NUM_SRC-1:0][LVL_W-1:0] lvl_nx, lvl_vec;
   logic [NUM_SRC-1:0]            elig;
   logic                          gate_open;
   logic                          win_v;
   logic [IDX_W-1:0]              win_idx;
   logic [LVL_W-1:0]              win_lvl;

   assign gate_open = !cpu_id_i && !cpu_np_i;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic ack_hit;
      assign ack_hit = ack_i && irq_valid_o && (irq_idx_o == IDX_W'(s));

      prio_intc_src #(
         .LVL_W  (LVL_W),
         .IDX_W  (IDX_W),
         .SRC_ID (s)
      ) u_src (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_i     (req_i[s]),
         .wr_en_i   (wr_en_i),
         .wr_idx_i  (wr_idx_i),
         .wr_data_i (wr_data_i),
         .ack_hit_i (ack_hit),
         .mask_nx_o (mask_nx[s]),
         .pend_nx_o (pend_nx[s]),
         .lvl_nx_o  (lvl_nx[s]),
         .mask_q_o  (mask_vec[s]),
         .pend_q_o  (pend_vec[s]),
         .lvl_q_o   (lvl_vec[s]),
         .req_q_o   (req_q[s])
      );

      assign elig[s] = pend_nx[s] && !mask_nx[s] && gate_open &&
                       (!svc_active_i || (lvl_nx[s] < svc_level_i));
   end

   prio_intc_arb #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .IDX_W   (IDX_W),
      .STYLE   (STYLE)
   ) u_arb (
      .elig_i    (elig),
      .lvl_i     (lvl_nx),
      .win_v_o   (win_v),
      .win_idx_o (win_idx),
      .win_lvl_o (win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid_o <= 1'b0;
         irq_idx_o   <= '0;
         irq_level_o <= '0;
      end else begin
         irq_valid_o <= win_v;
         irq_idx_o   <= win_idx;
         irq_level_o <= win_lvl;
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (rd_idx_i == IDX_W'(i)) begin
            rd_data_o = ctrl_pack(mask_vec[i], pend_vec[i], MAX_LVL_W'(lvl_vec[i]));
         end
      end
   end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int NUM_SRC = 33,
   parameter int LVL_W   = 3,
   parameter int IDX_W   = 6
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_SRC-1:0]              req_i,
   input logic [NUM_SRC-1:0]              req_q,
   input logic [NUM_SRC-1:0]              mask_vec,
   input logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_vec,
   input logic                            cpu_id_i,
   input logic                            cpu_np_i,
   input logic                            svc_active_i,
   input logic [LVL_W-1:0]                svc_level_i,
   input logic                            ack_i,
   input logic                            irq_valid_o,
   input logic [IDX_W-1:0]                irq_idx_o,
   input logic [LVL_W-1:0]                irq_level_o
);
   AST_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> !mask_vec[irq_idx_o]); // R3

   AST_CPU_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid_o) |-> (!$past(cpu_id_i) && !$past(cpu_np_i))); // R4

   AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (irq_level_o == lvl_vec[irq_idx_o])); // R5

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (32'(irq_idx_o) < NUM_SRC)); // R6

   AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && $past(svc_active_i) && $past(rst_n)) |->
         (irq_level_o < $past(svc_level_i))); // R7

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_valid_o && !(req_i[irq_idx_o] && !req_q[irq_idx_o])) |=>
         !(irq_valid_o && (irq_idx_o == $past(irq_idx_o)))); // R8
endmodule

bind prio_intc prio_intc_chk #(
   .NUM_SRC (NUM_SRC),
   .LVL_W   (LVL_W),
   .IDX_W   (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .req_q        (req_q),
   .mask_vec     (mask_vec),
   .lvl_vec      (lvl_vec),
   .cpu_id_i     (cpu_id_i),
   .cpu_np_i     (cpu_np_i),
   .svc_active_i (svc_active_i),
   .svc_level_i  (svc_level_i),
   .ack_i        (ack_i),
   .irq_valid_o  (irq_valid_o),
   .irq_idx_o    (irq_idx_o),
   .irq_level_o  (irq_level_o)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
   localparam int N  = 33;
   localparam int IW = 6;
   localparam int LW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [7:0]    wr_data = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [7:0]    rd_data;
   logic          cpu_id = 1'b0, cpu_np = 1'b0, svc_active = 1'b0;
   logic [LW-1:0] svc_level = '0;
   logic          ack = 1'b0;
   logic          irq_valid;
   logic [IW-1:0] irq_idx;
   logic [LW-1:0] irq_level;

   int  tests = 0;
   int  fails = 0;
   bit  done = 0;

   always #2 clk = ~clk;

   prio_intc uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
      .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .cpu_id_i(cpu_id), .cpu_np_i(cpu_np), .svc_active_i(svc_active),
      .svc_level_i(svc_level), .ack_i(ack), .irq_valid_o(irq_valid),
      .irq_idx_o(irq_idx), .irq_level_o(irq_level)
   );

   // behavioural reference model
   bit m_mask [N];
   bit m_pend [N];
   int m_lvl  [N];
   bit m_prev [N];
   bit e_valid;
   int e_idx, e_lvl;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_mask[i] = 1; m_pend[i] = 0; m_lvl[i] = 7; m_prev[i] = 0;
         end
         e_valid = 0; e_idx = 0; e_lvl = 0;
      end else begin
         int best;
         best = -1;
         for (int i = 0; i < N; i++) begin
            if (wr_en && int'(wr_idx) == i) begin
               m_mask[i] = wr_data[7];
               m_lvl[i]  = int'(wr_data[2:0]);
               if (!wr_data[6]) m_pend[i] = 0;
            end
            if (ack && e_valid && e_idx == i) m_pend[i] = 0;
            if (req[i] && !m_prev[i]) m_pend[i] = 1;
            m_prev[i] = req[i];
         end
         for (int i = 0; i < N; i++) begin
            if (m_pend[i] && !m_mask[i] && !cpu_id && !cpu_np &&
                (!svc_active || m_lvl[i] < int'(svc_level))) begin
               if (best < 0 || m_lvl[i] < m_lvl[best]) best = i;
            end
         end
         e_valid = (best >= 0);
         if (best >= 0) begin
            e_idx = best; e_lvl = m_lvl[best];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         tests++;
         if (irq_valid !== e_valid ||
             (e_valid && (int'(irq_idx) != e_idx || int'(irq_level) != e_lvl))) begin
            fails++;
            $display("FAIL R10 per-cycle model: actual v=%0d i=%0d l=%0d expected v=%0d i=%0d l=%0d",
                     irq_valid, irq_idx, irq_level, e_valid, e_idx, e_lvl);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input bit v, input int idx, input int lvl);
      chk({tag, " valid"}, int'(irq_valid), int'(v));
      if (v) begin
         chk({tag, " idx"}, int'(irq_idx), idx);
         chk({tag, " level"}, int'(irq_level), lvl);
      end
   endtask

   task automatic rd(input string tag, input int idx, input int exp);
      rd_idx = IW'(idx); #0.5;
      chk(tag, int'(rd_data), exp);
   endtask

   task automatic wr(input int idx, input int data);
      wr_en = 1; wr_idx = IW'(idx); wr_data = 8'(data);
      tick();
      wr_en = 0;
   endtask

   task automatic do_ack();
      ack = 1; tick(); ack = 0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk_out("R1 reset", 0, 0, 0);
      rd("R1 src0 ctrl", 0, 8'h87);
      rd("R1 src32 ctrl", 32, 8'h87);

      // R10 latency and R2 edge capture
      wr(5, 8'h43);
      req[5] = 1; tick();
      chk_out("R10 first edge", 1, 5, 3);
      rd("R2 pending set", 5, 8'h43);
      do_ack();
      chk_out("R8 ack single", 0, 0, 0);
      tick(); tick();
      rd("R2 held high no reset", 5, 8'h03);
      req[5] = 0;

      // R5 and R6 level then index ordering
      wr(7, 8'h42); wr(20, 8'h41); wr(3, 8'h41);
      req[7] = 1; req[20] = 1; req[3] = 1; tick();
      req = '0;
      chk_out("R6 tie lowest index", 1, 3, 1);
      do_ack();
      chk_out("R8 next winner", 1, 20, 1);
      do_ack();
      chk_out("R5 lower level last", 1, 7, 2);
      do_ack();
      chk_out("R8 drained", 0, 0, 0);

      // R3 masked source kept pending
      wr(10, 8'h84);
      req[10] = 1; tick(); req[10] = 0;
      chk_out("R3 masked not offered", 0, 0, 0);
      rd("R3 pending kept", 10, 8'hC4);
      wr(10, 8'h44);
      chk_out("R3 unmask offers", 1, 10, 4);
      rd("R9 keep-pending bit", 10, 8'h44);
      do_ack();

      // R4 CPU status gating
      wr(32, 8'h40);
      cpu_id = 1;
      req[32] = 1; tick(); req[32] = 0;
      chk_out("R4 disable blocks", 0, 0, 0);
      cpu_id = 0; cpu_np = 1; tick();
      chk_out("R4 nmi blocks", 0, 0, 0);
      cpu_np = 0; tick();
      chk_out("R4 released", 1, 32, 0);
      do_ack();

      // R7 strict nesting
      svc_active = 1; svc_level = 3'd2;
      wr(12, 8'h42); wr(13, 8'h41);
      req[12] = 1; tick(); req[12] = 0;
      chk_out("R7 equal level waits", 0, 0, 0);
      req[13] = 1; tick(); req[13] = 0;
      chk_out("R7 higher level nests", 1, 13, 1);
      do_ack();
      chk_out("R7 equal still waits", 0, 0, 0);
      svc_active = 0; tick();
      chk_out("R7 service ended", 1, 12, 2);
      wr(12, 8'h02);
      chk_out("R9 write clears pending", 0, 0, 0);
      rd("R9 cleared ctrl", 12, 8'h02);

      // R9 out-of-range index
      wr(40, 8'h00);
      rd("R9 out of range src8", 8, 8'h87);
      rd("R9 out of range src0", 0, 8'h87);

      // random phase checked by the model
      for (int c = 0; c < 3000; c++) begin
         for (int b = 0; b < N; b++) if ($urandom_range(0, 15) == 0) req[b] = ~req[b];
         wr_en = ($urandom_range(0, 7) == 0);
         wr_idx = IW'($urandom_range(0, 36));
         wr_data = 8'($urandom_range(0, 255)) & 8'b0111_1111 | (($urandom_range(0, 3) == 0) ? 8'h80 : 8'h00);
         ack = irq_valid && ($urandom_range(0, 2) == 0);
         cpu_id = ($urandom_range(0, 9) == 0);
         cpu_np = ($urandom_range(0, 19) == 0);
         svc_active = ($urandom_range(0, 3) == 0);
         svc_level = LW'($urandom_range(0, 7));
         tick();
      end
      wr_en = 0; ack = 0; cpu_id = 0; cpu_np = 0; svc_active = 0;
      tick();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule